// File: doc/BRIEF.md
# Decimal Product Exponent and Shift Control

This block sits in the control path of a sequential decimal floating-point multiplier. It takes the two biased operand exponents and the leading-zero digit counts of both significands. From these it works out where the decimal point of the double-width product lands and how far that product should be moved. The normalising shift is therefore known before the iterative accumulation finishes, and the product never needs its own leading-zero count.

Each accepted request yields several values: the preferred exponent, the intermediate exponent (the point sits `P` digits into the `2P`-digit product), a left-shift amount, a right-shift amount for gradual underflow, and the exponent that results once those shifts are applied. When the plainly normalised exponent would leave the range `[EMIN, EMAX]`, the block raises an overflow or underflow flag and trades shift against range. On overflow it removes every leading zero. On underflow it shortens the left shift and turns any remaining deficit into a right shift. That right shift saturates at `2P+2` digits. The left shift can be one digit short of exact, and a later stage corrects this using a guard digit. Results are registered and appear one cycle after a request.

Top module: `dec_mul_exp_ctl`

## Requirements
- R1: `prefExp` equals `expA + expB - BIAS`, as a signed value.
- R2: `intExp` equals `prefExp + P`.
- R3: When neither overflow nor underflow applies, `shiftLeft` is the smaller of `P` and `lzA + lzB`, `shiftRight` is 0, and `shiftedExp` is `intExp - shiftLeft`.
- R4: If `intExp - min(lzA+lzB, P)` exceeds `EMAX`, then `overflow` is 1, `shiftLeft` is raised to `lzA + lzB`, and `shiftedExp` is `intExp - (lzA + lzB)`.
- R5: If `intExp >= EMIN` but `intExp - min(lzA+lzB, P)` is below `EMIN`, then `underflow` is 1, `shiftLeft` is `intExp - EMIN`, `shiftRight` is 0, and `shiftedExp` is `EMIN`.
- R6: If `intExp < EMIN`, then `underflow` is 1, `shiftLeft` is 0, `shiftRight` is `min(EMIN - intExp, 2P+2)`, and `shiftedExp` is `intExp + shiftRight`.
- R7: A normalised exponent exactly equal to `EMAX` or to `EMIN` raises neither flag. `overflow` and `underflow` are never both 1.
- R8: The outputs update on the clock edge at which `inValid` is 1, and `outValid` is 1 during the following cycle. While `inValid` is 0, all result outputs hold their values and `outValid` is 0.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| expA | input | EW | Biased exponent of operand A |
| expB | input | EW | Biased exponent of operand B |
| lzA | input | LZW | Leading-zero digit count of A's significand (0..P) |
| lzB | input | LZW | Leading-zero digit count of B's significand (0..P) |
| outValid | output | 1 | Result strobe, one cycle after request |
| prefExp | output | XW | Preferred exponent, signed |
| intExp | output | XW | Intermediate exponent, signed |
| shiftLeft | output | SW | Left-shift amount in digits |
| shiftRight | output | SW | Right-shift amount in digits |
| shiftedExp | output | XW | Exponent after the shifts, signed |
| overflow | output | 1 | Exponent range exceeded |
| underflow | output | 1 | Exponent below range |

## Verification
The bench uses the defaults: `P = 16`, `BIAS = 398`, `EMIN = 0`, `EMAX = 767`, and 10-bit exponents. With these values, two large operand exponents push the intermediate exponent far above `EMAX`. Two tiny ones drive it below `-2P-2`, so saturation of the right shift is reachable. The vectors land exactly on `EMIN`, one below it, exactly on `EMAX`, and one above it. They also cover leading-zero sums both above and below `P`, so the clamp, the overflow raise and the underflow trim are each exercised.

// File: rtl/dec_mul_exp_pkg.sv
package dec_mul_exp_pkg;
  typedef struct packed {
    logic rightSel;
    logic underSel;
    logic overSel;
  } shiftStrobe_t;
endpackage

// File: rtl/dec_mul_exp_ctrl.sv
module dec_mul_exp_ctrl
  import dec_mul_exp_pkg::*;
#(
  parameter int XW   = 13,
  parameter int EMIN = 0,
  parameter int EMAX = 767
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [XW-1:0] intExpC,
  input  logic signed [XW-1:0] baseExpC,
  output shiftStrobe_t         strobe
);
  localparam logic signed [XW-1:0] EMIN_X = XW'(EMIN);
  localparam logic signed [XW-1:0] EMAX_X = XW'(EMAX);

  // Priority: a deficit before any shift wins, then a deficit after
  // normalising, then an excess.
  always_comb begin
    strobe = '0;
    if (intExpC < EMIN_X)        strobe.rightSel = 1'b1;
    else if (baseExpC < EMIN_X)  strobe.underSel = 1'b1;
    else if (baseExpC > EMAX_X)  strobe.overSel  = 1'b1;
  end

  // R7: at most one adjustment is selected
  p_one_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rightSel, strobe.underSel, strobe.overSel}));
endmodule

// File: rtl/dec_mul_exp_dp.sv
module dec_mul_exp_dp
  import dec_mul_exp_pkg::*;
#(
  parameter int P    = 16,
  parameter int EW   = 10,
  parameter int BIAS = 398,
  parameter int EMIN = 0,
  parameter int EMAX = 767,
  parameter int LZW  = 5,
  parameter int SW   = 6,
  parameter int XW   = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EW-1:0]        expA,
  input  logic [EW-1:0]        expB,
  input  logic [LZW-1:0]       lzA,
  input  logic [LZW-1:0]       lzB,
  input  shiftStrobe_t         strobe,
  output logic signed [XW-1:0] intExpC,
  output logic signed [XW-1:0] baseExpC,
  output logic                 outValid,
  output logic signed [XW-1:0] prefExp,
  output logic signed [XW-1:0] intExp,
  output logic [SW-1:0]        shiftLeft,
  output logic [SW-1:0]        shiftRight,
  output logic signed [XW-1:0] shiftedExp,
  output logic                 overflow,
  output logic                 underflow
);
  localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);
  localparam logic signed [XW-1:0] P_X    = XW'(P);
  localparam logic signed [XW-1:0] EMIN_X = XW'(EMIN);
  localparam logic signed [XW-1:0] EMAX_X = XW'(EMAX);
  localparam logic [SW-1:0]        P_S    = SW'(P);
  localparam int                   SAT    = 2 * P + 2;
  localparam logic signed [XW-1:0] SAT_X  = XW'(SAT);

  logic signed [XW-1:0] prefExpC;
  logic signed [XW-1:0] deficit;
  logic [SW-1:0]        lzSum;
  logic [SW-1:0]        baseSla;
  logic [SW-1:0]        slaN;
  logic [SW-1:0]        rsaN;
  logic signed [XW-1:0] shExpN;

  always_comb begin
    prefExpC = $signed(XW'(expA)) + $signed(XW'(expB)) - BIAS_X;
    intExpC  = prefExpC + P_X;
    lzSum    = SW'(lzA) + SW'(lzB);
    baseSla  = (lzSum > P_S) ? P_S : lzSum;
    baseExpC = intExpC - $signed(XW'(baseSla));
    deficit  = EMIN_X - intExpC;
    slaN     = baseSla;
    rsaN     = '0;
    if (strobe.rightSel) begin
      slaN = '0;
      rsaN = (deficit > SAT_X) ? SW'(SAT) : SW'(deficit);
    end else if (strobe.underSel) begin
      slaN = SW'(intExpC - EMIN_X);
    end else if (strobe.overSel) begin
      slaN = lzSum;
    end
    shExpN = intExpC - $signed(XW'(slaN)) + $signed(XW'(rsaN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      prefExp    <= '0;
      intExp     <= '0;
      shiftLeft  <= '0;
      shiftRight <= '0;
      shiftedExp <= '0;
      overflow   <= 1'b0;
      underflow  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        prefExp    <= prefExpC;
        intExp     <= intExpC;
        shiftLeft  <= slaN;
        shiftRight <= rsaN;
        shiftedExp <= shExpN;
        overflow   <= strobe.overSel;
        underflow  <= strobe.rightSel | strobe.underSel;
      end
    end
  end

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(shiftedExp) && $stable(shiftLeft) && $stable(shiftRight));
  p_sla_clamp_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !overflow |-> shiftLeft <= P_S);
  p_right_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && shiftRight != '0 |-> underflow && shiftLeft == '0);
  p_right_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    shiftRight <= SW'(SAT));
  p_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !overflow && shiftRight == '0 |-> shiftedExp >= EMIN_X);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !overflow |-> shiftedExp <= EMAX_X);
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow));
endmodule

// File: rtl/dec_mul_exp_ctl.sv
module dec_mul_exp_ctl
  import dec_mul_exp_pkg::*;
#(
  parameter int P    = 16,
  parameter int EW   = 10,
  parameter int BIAS = 398,
  parameter int EMIN = 0,
  parameter int EMAX = 767,
  localparam int LZW = $clog2(P + 1),
  localparam int SW  = $clog2(2 * P + 3),
  localparam int XW  = EW + 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EW-1:0]        expA,
  input  logic [EW-1:0]        expB,
  input  logic [LZW-1:0]       lzA,
  input  logic [LZW-1:0]       lzB,
  output logic                 outValid,
  output logic signed [XW-1:0] prefExp,
  output logic signed [XW-1:0] intExp,
  output logic [SW-1:0]        shiftLeft,
  output logic [SW-1:0]        shiftRight,
  output logic signed [XW-1:0] shiftedExp,
  output logic                 overflow,
  output logic                 underflow
);
  shiftStrobe_t         strobe;
  logic signed [XW-1:0] intExpC;
  logic signed [XW-1:0] baseExpC;

  dec_mul_exp_ctrl #(.XW(XW), .EMIN(EMIN), .EMAX(EMAX)) i_ctrl (
    .clk(clk), .rstN(rstN), .intExpC(intExpC), .baseExpC(baseExpC),
    .strobe(strobe)
  );

  dec_mul_exp_dp #(.P(P), .EW(EW), .BIAS(BIAS), .EMIN(EMIN), .EMAX(EMAX),
                   .LZW(LZW), .SW(SW), .XW(XW)) i_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .expA(expA), .expB(expB),
    .lzA(lzA), .lzB(lzB), .strobe(strobe), .intExpC(intExpC),
    .baseExpC(baseExpC), .outValid(outValid), .prefExp(prefExp),
    .intExp(intExp), .shiftLeft(shiftLeft), .shiftRight(shiftRight),
    .shiftedExp(shiftedExp), .overflow(overflow), .underflow(underflow)
  );
endmodule

// File: tb/test_dec_mul_exp_ctl.sv
module test_dec_mul_exp_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [9:0] expA = '0, expB = '0;
  logic [4:0] lzA = '0, lzB = '0;
  logic outValid, overflow, underflow;
  logic signed [12:0] prefExp, intExp, shiftedExp;
  logic [5:0] shiftLeft, shiftRight;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dec_mul_exp_ctl i_dec_mul_exp_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .expA(expA), .expB(expB),
    .lzA(lzA), .lzB(lzB), .outValid(outValid), .prefExp(prefExp),
    .intExp(intExp), .shiftLeft(shiftLeft), .shiftRight(shiftRight),
    .shiftedExp(shiftedExp), .overflow(overflow), .underflow(underflow)
  );

  // expA expB lzA lzB | pref int sla rsa shExp ovf unf
  localparam int NV = 15;
  localparam int VEC [NV][11] = '{
    '{398, 398, 0, 0,   398, 414, 0, 0, 414, 0, 0},   // R1 R2 R3
    '{400, 390, 5, 7,   392, 408, 12, 0, 396, 0, 0},  // R3
    '{398, 398, 10, 9,  398, 414, 16, 0, 398, 0, 0},  // R3 clamp at P
    '{100, 290, 10, 3,  -8, 8, 8, 0, 0, 0, 1},        // R5
    '{100, 280, 4, 4,   -18, -2, 0, 2, 0, 0, 1},      // R6
    '{0, 0, 0, 0,       -398, -382, 0, 34, -348, 0, 1}, // R6 saturated
    '{1000, 170, 10, 12, 772, 788, 22, 0, 766, 1, 0}, // R4 raise
    '{1023, 1023, 0, 0, 1648, 1664, 0, 0, 1664, 1, 0}, // R4
    '{199, 183, 0, 0,   -16, 0, 0, 0, 0, 0, 0},       // R7 at EMIN
    '{199, 183, 1, 0,   -16, 0, 0, 0, 0, 0, 1},       // R5 edge
    '{199, 182, 0, 0,   -17, -1, 0, 1, 0, 0, 1},      // R6 edge
    '{575, 574, 0, 0,   751, 767, 0, 0, 767, 0, 0},   // R7 at EMAX
    '{575, 575, 0, 0,   752, 768, 0, 0, 768, 1, 0},   // R4 edge
    '{200, 148, 0, 0,   -50, -34, 0, 34, 0, 0, 1},    // R6 exactly 2P+2
    '{200, 147, 0, 0,   -51, -35, 0, 34, -1, 0, 1}    // R6 beyond 2P+2
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9", "outValid", int'(outValid), 0);
    chk("R9", "shiftedExp", int'(shiftedExp), 0);
    chk("R9", "flags", int'({overflow, underflow}), 0);
    chk("R9", "shifts", int'(shiftLeft) + int'(shiftRight), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      expA = 10'(VEC[i][0]); expB = 10'(VEC[i][1]);
      lzA = 5'(VEC[i][2]);   lzB = 5'(VEC[i][3]);
      inValid = 1'b1;
      @(negedge clk);
      chk("R8", "outValid", int'(outValid), 1);
      chk("R1", "prefExp", int'(prefExp), VEC[i][4]);
      chk("R2", "intExp", int'(intExp), VEC[i][5]);
      chk("R3", "shiftLeft", int'(shiftLeft), VEC[i][6]);
      chk("R6", "shiftRight", int'(shiftRight), VEC[i][7]);
      chk("R5", "shiftedExp", int'(shiftedExp), VEC[i][8]);
      chk("R4", "overflow", int'(overflow), VEC[i][9]);
      chk("R7", "underflow", int'(underflow), VEC[i][10]);
    end
    // R8: idle cycles hold the last result
    inValid = 1'b0;
    expA = 10'd1000; expB = 10'd1000; lzA = 5'd16; lzB = 5'd16;
    repeat (2) @(negedge clk);
    chk("R8", "idle outValid", int'(outValid), 0);
    chk("R8", "held shiftedExp", int'(shiftedExp), -1);
    chk("R8", "held shiftRight", int'(shiftRight), 34);
    chk("R8", "held overflow", int'(overflow), 0);
    // R9: reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R9", "reset prefExp", int'(prefExp), 0);
    chk("R9", "reset underflow", int'(underflow), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule